// File: doc/BRIEF.md
# Immediate-Operand Extended ALU Stage

This block is the write-back datapath for a group of rarely used immediate-mode instructions of an 8-bit accumulator processor. The sequencer presents an opcode byte, the immediate operand, the current accumulator (A), index register (X) and the four status flags. It raises a one-cycle execute strobe. On the clock edge that samples the strobe, the block registers the new A, X and flag values that the opcode calls for. The sequencer reads them back from the outputs.

The group covers seven operations, each an AND or a subtract fused with a second step. One ANDs and then copies the sign into the carry. Two AND and then shift or rotate. One is a masked subtract into X. One transfers X with a mask. One ORs a constant and then ANDs. One duplicates the ordinary subtract-with-borrow. Decimal arithmetic is not modelled. The two opcodes whose results vary between machines follow one fixed model here: a constant OR mask, and a plain X transfer.

Every opcode occupies the processor for two cycles: the fetch of the immediate, then the execute strobe. The block's own latency is one register stage after the strobe.

Top module: `imx_alu`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, a_out, x_out and all four flag outputs are 0 until the first execute strobe.
- R2: Opcodes 0x0B and 0x2B set A = A AND imm. N and Z come from the new A. C takes the same value as the new N. V and X are unchanged.
- R3: Opcode 0x4B computes t = A AND imm and sets A = t shifted right by one with a 0 entering bit 7. N becomes 0, Z comes from the new A, and C takes bit 0 of t. V and X are unchanged.
- R4: Opcode 0x6B computes t = A AND imm and sets A = {old C, t[7:1]}, discarding t[0]. C becomes t[7]. N and Z come from the new A. X is unchanged.
- R5: For opcode 0x6B, V becomes t[7] XOR t[6].
- R6: Opcode 0xCB sets X = (A AND X) - imm, ignoring the incoming carry. C = 1 when (A AND X) >= imm as unsigned values. N and Z come from the new X. A and V are unchanged.
- R7: Opcode 0x8B sets A = X AND imm. N and Z come from the new A. C, V and X are unchanged.
- R8: Opcode 0xAB sets both A and X to (A OR 0xEE) AND imm. N and Z come from that value. C and V are unchanged.
- R9: Opcode 0xEB sets A = A - imm - (1 - C). C is the no-borrow carry-out. V is the signed overflow of that subtraction. N and Z come from the new A. X is unchanged.
- R10: While exec_en is low, all outputs keep their values whatever the other inputs do.
- R11: On an execute strobe with any opcode outside the group, the outputs load a_in, x_in and the four flag inputs unchanged.
- R12: Results appear on the outputs after the first rising clock edge that samples exec_en high, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute strobe; outputs load on the edge that samples it high |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | DATA_W | Immediate operand |
| a_in | input | DATA_W | Current accumulator |
| x_in | input | DATA_W | Current index register |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| a_out | output | DATA_W | Accumulator write-back value |
| x_out | output | DATA_W | Index register write-back value |
| n_out | output | 1 | Negative flag write-back |
| z_out | output | 1 | Zero flag write-back |
| c_out | output | 1 | Carry flag write-back |
| v_out | output | 1 | Overflow flag write-back |

## Verification
Every result of this block (A, X and all four flags) is due exactly one rising edge after the edge that samples exec_en high. A value that an opcode leaves untouched is due at that same edge, copied from the inputs.

The bench changes inputs and the strobe only on falling edges. It lowers the strobe on the falling edge after the capture. It then reads the outputs in that same half cycle, so each check sees the value registered by exactly one strobe.

The hold and reset checks work the same way. The bench disturbs the inputs on a falling edge with the strobe low, lets a full rising edge pass, and samples on the next falling edge.

// File: rtl/imx_pkg.sv
package imx_pkg;

  localparam logic [7:0] OPC_ANDC_0 = 8'h0B;
  localparam logic [7:0] OPC_ANDC_1 = 8'h2B;
  localparam logic [7:0] OPC_ANDLSR = 8'h4B;
  localparam logic [7:0] OPC_ANDROR = 8'h6B;
  localparam logic [7:0] OPC_XFERM  = 8'h8B;
  localparam logic [7:0] OPC_ORCAND = 8'hAB;
  localparam logic [7:0] OPC_MSUBX  = 8'hCB;
  localparam logic [7:0] OPC_SBCDUP = 8'hEB;

  typedef enum logic [2:0] {
    OP_PASS   = 3'd0,
    OP_ANDC   = 3'd1,
    OP_ANDLSR = 3'd2,
    OP_ANDROR = 3'd3,
    OP_MSUBX  = 3'd4,
    OP_XFERM  = 3'd5,
    OP_ORCAND = 3'd6,
    OP_SBC    = 3'd7
  } imx_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } imx_flags_t;

endpackage

// File: rtl/imx_decode.sv
module imx_decode
  import imx_pkg::*;
(
  input  logic [7:0] opcode,
  output imx_op_e    op
);

  always_comb begin
    unique case (opcode)
      OPC_ANDC_0, OPC_ANDC_1: op = OP_ANDC;
      OPC_ANDLSR:             op = OP_ANDLSR;
      OPC_ANDROR:             op = OP_ANDROR;
      OPC_MSUBX:              op = OP_MSUBX;
      OPC_XFERM:              op = OP_XFERM;
      OPC_ORCAND:             op = OP_ORCAND;
      OPC_SBCDUP:             op = OP_SBC;
      default:                op = OP_PASS;
    endcase
  end

endmodule

// File: rtl/imx_datapath.sv
module imx_datapath
  import imx_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] ORC_MASK = 'hEE
) (
  input  imx_op_e           op,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  imx_flags_t        flg_in,
  output logic [DATA_W-1:0] a_nxt,
  output logic [DATA_W-1:0] x_nxt,
  output imx_flags_t        flg_nxt
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] and_ai;
  logic [DATA_W-1:0] and_ax;
  logic [DATA_W:0]   diff_mx;
  logic [DATA_W:0]   sum_sbc;
  logic [DATA_W-1:0] nz_src;

  always_comb begin
    and_ai  = a_in & imm;
    and_ax  = a_in & x_in;
    diff_mx = {1'b0, and_ax} + {1'b0, ~imm} + (DATA_W+1)'(1);
    sum_sbc = {1'b0, a_in} + {1'b0, ~imm} + {{DATA_W{1'b0}}, flg_in.c};
  end

  always_comb begin
    a_nxt   = a_in;
    x_nxt   = x_in;
    flg_nxt = flg_in;
    nz_src  = a_in;
    unique case (op)
      OP_ANDC: begin
        a_nxt     = and_ai;
        nz_src    = and_ai;
        flg_nxt.c = and_ai[MSB];
      end
      OP_ANDLSR: begin
        a_nxt     = {1'b0, and_ai[MSB:1]};
        nz_src    = a_nxt;
        flg_nxt.c = and_ai[0];
      end
      OP_ANDROR: begin
        a_nxt     = {flg_in.c, and_ai[MSB:1]};
        nz_src    = a_nxt;
        flg_nxt.c = and_ai[MSB];
        flg_nxt.v = and_ai[MSB] ^ and_ai[MSB-1];
      end
      OP_MSUBX: begin
        x_nxt     = diff_mx[MSB:0];
        nz_src    = x_nxt;
        flg_nxt.c = diff_mx[DATA_W];
      end
      OP_XFERM: begin
        a_nxt  = x_in & imm;
        nz_src = a_nxt;
      end
      OP_ORCAND: begin
        a_nxt  = (a_in | ORC_MASK) & imm;
        x_nxt  = a_nxt;
        nz_src = a_nxt;
      end
      OP_SBC: begin
        a_nxt     = sum_sbc[MSB:0];
        nz_src    = a_nxt;
        flg_nxt.c = sum_sbc[DATA_W];
        flg_nxt.v = (a_in[MSB] ^ imm[MSB]) & (a_in[MSB] ^ sum_sbc[MSB]);
      end
      default: begin
        nz_src = a_in;
      end
    endcase
    if (op != OP_PASS) begin
      flg_nxt.n = nz_src[MSB];
      flg_nxt.z = (nz_src == '0);
    end
  end

endmodule

// File: rtl/imx_wb_reg.sv
module imx_wb_reg
  import imx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] a_d,
  input  logic [DATA_W-1:0] x_d,
  input  imx_flags_t        flg_d,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] x_q,
  output imx_flags_t        flg_q
);

  logic [DATA_W-1:0] a_sel;
  logic [DATA_W-1:0] x_sel;
  imx_flags_t        flg_sel;

  always_comb begin
    if (load_en) begin
      a_sel   = a_d;
      x_sel   = x_d;
      flg_sel = flg_d;
    end else begin
      a_sel   = a_q;
      x_sel   = x_q;
      flg_sel = flg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      x_q   <= '0;
      flg_q <= '0;
    end else begin
      a_q   <= a_sel;
      x_q   <= x_sel;
      flg_q <= flg_sel;
    end
  end

endmodule

// File: rtl/imx_alu.sv
module imx_alu
  import imx_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] ORC_MASK = 'hEE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              c_in,
  input  logic              v_in,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] x_out,
  output logic              n_out,
  output logic              z_out,
  output logic              c_out,
  output logic              v_out
);

  imx_op_e           op_dec;
  imx_flags_t        flg_cur;
  imx_flags_t        flg_calc;
  imx_flags_t        flg_reg;
  logic [DATA_W-1:0] a_calc;
  logic [DATA_W-1:0] x_calc;

  assign flg_cur = '{n: n_in, z: z_in, c: c_in, v: v_in};

  imx_decode u_dec (
    .opcode (opcode),
    .op     (op_dec)
  );

  imx_datapath #(
    .DATA_W   (DATA_W),
    .ORC_MASK (ORC_MASK)
  ) u_dp (
    .op      (op_dec),
    .imm     (imm),
    .a_in    (a_in),
    .x_in    (x_in),
    .flg_in  (flg_cur),
    .a_nxt   (a_calc),
    .x_nxt   (x_calc),
    .flg_nxt (flg_calc)
  );

  imx_wb_reg #(
    .DATA_W (DATA_W)
  ) u_wb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (exec_en),
    .a_d     (a_calc),
    .x_d     (x_calc),
    .flg_d   (flg_calc),
    .a_q     (a_out),
    .x_q     (x_out),
    .flg_q   (flg_reg)
  );

  assign n_out = flg_reg.n;
  assign z_out = flg_reg.z;
  assign c_out = flg_reg.c;
  assign v_out = flg_reg.v;

endmodule

// File: rtl/imx_alu_chk.sv
module imx_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_en,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] imm,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] x_in,
  input logic              c_in,
  input logic              v_in,
  input logic [DATA_W-1:0] a_out,
  input logic [DATA_W-1:0] x_out,
  input logic              n_out,
  input logic              z_out,
  input logic              c_out,
  input logic              v_out
);

  localparam int MSB = DATA_W - 1;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> ($stable(a_out) && $stable(x_out) && $stable(n_out)
                  && $stable(z_out) && $stable(c_out) && $stable(v_out)));

  a_r2_carry_is_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (opcode == 8'h0B || opcode == 8'h2B)) |=> (c_out == n_out));

  a_r3_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'h4B) |=> (!n_out && c_out == $past(a_in[0] & imm[0])));

  a_r4_carry_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'h6B) |=>
      (a_out[MSB] == $past(c_in) && c_out == $past(a_in[MSB] & imm[MSB])));

  a_r6_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'hCB) |=> (a_out == $past(a_in) && v_out == $past(v_in)));

  a_r8_both_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'hAB) |=> (a_out == x_out && z_out == (x_out == '0)));

  a_r7_x_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 8'h8B) |=> (x_out == $past(x_in) && c_out == $past(c_in)));

endmodule

bind imx_alu imx_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .exec_en (exec_en),
  .opcode  (opcode),
  .imm     (imm),
  .a_in    (a_in),
  .x_in    (x_in),
  .c_in    (c_in),
  .v_in    (v_in),
  .a_out   (a_out),
  .x_out   (x_out),
  .n_out   (n_out),
  .z_out   (z_out),
  .c_out   (c_out),
  .v_out   (v_out)
);

// File: tb/imx_alu_tb.sv
module imx_alu_tb;

  logic       clk;
  logic       rst_n;
  logic       exec_en;
  logic [7:0] opcode, imm, a_in, x_in;
  logic       n_in, z_in, c_in, v_in;
  logic [7:0] a_out, x_out;
  logic       n_out, z_out, c_out, v_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  imx_alu u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode), .imm(imm),
    .a_in(a_in), .x_in(x_in), .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
    .a_out(a_out), .x_out(x_out), .n_out(n_out), .z_out(z_out),
    .c_out(c_out), .v_out(v_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // stimulus: {opcode, imm, a, x, flags {n,z,c,v}}
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {8'h0B, 8'hFF, 8'h80, 8'h00, 4'b0000},
    {8'h2B, 8'h0F, 8'hF0, 8'h11, 4'b0011},
    {8'h4B, 8'hFF, 8'h03, 8'h22, 4'b1001},
    {8'h4B, 8'h0E, 8'h03, 8'h22, 4'b0010},
    {8'h6B, 8'hFF, 8'hC1, 8'h00, 4'b0000},
    {8'h6B, 8'h7F, 8'h41, 8'h00, 4'b0010},
    {8'hCB, 8'h5A, 8'hFF, 8'hF0, 4'b0001},
    {8'hCB, 8'h10, 8'h0F, 8'h00, 4'b0010},
    {8'hCB, 8'h33, 8'h33, 8'h33, 4'b1000},
    {8'h8B, 8'h44, 8'h12, 8'hF6, 4'b0011},
    {8'hAB, 8'hAA, 8'h00, 8'h55, 4'b0000},
    {8'hAB, 8'h00, 8'h7F, 8'h55, 4'b1010},
    {8'hEB, 8'h01, 8'h00, 8'h09, 4'b0010},
    {8'hEB, 8'h01, 8'h80, 8'h09, 4'b0010},
    {8'hEB, 8'h00, 8'h05, 8'h09, 4'b0000},
    {8'h1A, 8'h77, 8'h9C, 8'h3D, 4'b1011}
  };

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h0B, 8'h2B: return "R2";
      8'h4B:        return "R3";
      8'h6B:        return "R4/R5";
      8'hCB:        return "R6";
      8'h8B:        return "R7";
      8'hAB:        return "R8";
      8'hEB:        return "R9";
      default:      return "R11";
    endcase
  endfunction

  // reference: documented-instruction sequences, result {a, x, n, z, c, v}
  function automatic logic [19:0] ref_model(input logic [35:0] s);
    logic [7:0] op, im, a, x, t;
    logic n, z, c, v;
    logic [8:0] w;
    {op, im, a, x, n, z, c, v} = s;
    case (op)
      8'h0B, 8'h2B: begin a = a & im; c = a[7]; end
      8'h4B: begin a = a & im; c = a[0]; a = a >> 1; end
      8'h6B: begin t = a & im; v = t[7] ^ t[6]; a = {c, t[7:1]}; c = t[7]; end
      8'hCB: begin t = a & x; c = (t >= im); x = t - im; end
      8'h8B: begin a = x; a = a & im; end
      8'hAB: begin a = a | 8'hEE; a = a & im; x = a; end
      8'hEB: begin
        w = {1'b0, a} - {1'b0, im} - {8'h00, ~c};
        v = ((a[7] != im[7]) && (w[7] != a[7]));
        c = ~w[8];
        a = w[7:0];
      end
      default: ;
    endcase
    case (op)
      8'hCB: begin n = x[7]; z = (x == 0); end
      8'h0B, 8'h2B, 8'h4B, 8'h6B, 8'h8B, 8'hAB, 8'hEB:
        begin n = a[7]; z = (a == 0); end
      default: ;
    endcase
    return {a, x, n, z, c, v};
  endfunction

  task automatic check(input string req, input logic [19:0] exp_v);
    logic [19:0] act;
    act = {a_out, x_out, n_out, z_out, c_out, v_out};
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual a=%h x=%h nzcv=%b expected a=%h x=%h nzcv=%b",
               req, act[19:12], act[11:4], act[3:0],
               exp_v[19:12], exp_v[11:4], exp_v[3:0]);
    end
  endtask

  task automatic drive(input logic [35:0] s, input logic en);
    {opcode, imm, a_in, x_in, n_in, z_in, c_in, v_in} = s;
    exec_en = en;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [19:0] last;
    rst_n = 1'b0;
    drive(36'h0, 1'b0);
    repeat (2) @(negedge clk);
    check("R1", 20'h0);
    rst_n = 1'b1;
    drive(VEC[0], 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R1", 20'h0);   // no strobe yet: still reset value (R12)

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      @(negedge clk);
      exec_en = 1'b0;
      check(tag_of(VEC[i][35:28]), ref_model(VEC[i]));
    end

    // R12: result appears only after the capturing edge
    last = ref_model(VEC[NV-1]);
    drive(VEC[4], 1'b1);
    @(posedge clk);
    #1;
    check("R12", ref_model(VEC[4]));
    @(negedge clk);
    exec_en = 1'b0;

    // R10: inputs change with strobe low; outputs hold
    last = ref_model(VEC[4]);
    drive(VEC[9], 1'b0);
    @(negedge clk);
    drive(VEC[11], 1'b0);
    @(negedge clk);
    check("R10", last);

    // R5 corner: bit7=0 bit6=1 gives V=1, carry-in 0 into bit7
    drive({8'h6B, 8'h40, 8'h40, 8'h00, 4'b0000}, 1'b1);
    @(negedge clk);
    exec_en = 1'b0;
    check("R5", {8'h20, 8'h00, 4'b0001});

    // R6 corner: equal operands, incoming carry 0 ignored
    drive({8'hCB, 8'h80, 8'hC0, 8'h80, 4'b0000}, 1'b1);
    @(negedge clk);
    exec_en = 1'b0;
    check("R6", {8'hC0, 8'h00, 4'b0110});

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 20'h0);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end

endmodule